// File: doc/BRIEF.md
# Relocatable Module Window Decoder

The block places every on-chip module register inside one 4 KB address window. The window is aligned on a 4 KB boundary and can be moved at run time. Software moves it by writing a base register. That register is reached at exactly one address, 32'h0003FF00, and only when the function code shows a CPU-space access (3'b111). Reads of that address return the stored value.

Each ordinary (non-CPU-space) access is compared with the stored base. On a match the block raises a module-select line and presents the 12-bit offset into the window to the module fabric. The base register holds address bits 31:12 and a valid flag in bit 0. Until the flag is set, no window is decoded. Accesses to the base register are acknowledged one clock after they are strobed.

Top module: `module_window_decoder`

## Requirements
- R1: After reset, `ack_o` is low, `sel_o` is low for every address, and a read of the base register returns 32'h0.
- R2: A strobed write (`rw_i`=0) with `fc_i`=3'b111 and `addr_i`=32'h0003FF00 loads `wdata_i[31:12]` as the base and `wdata_i[0]` as the valid flag. `wdata_i[11:1]` is ignored and reads back as zero.
- R3: A strobed read (`rw_i`=1) of the base register returns {base[31:12], 11'b0, valid} on `rdata_o` in the same cycle that `ack_o` is high. `rdata_o` is zero in every other cycle.
- R4: `ack_o` is high for exactly the one cycle after a strobed base-register access, and at no other time. An access with the right address but the wrong function code, or the right function code but the wrong address, is not acknowledged and does not change the base register.
- R5: `sel_o` is high in the same cycle, combinationally, when `strb_i` is high, `fc_i` is not 3'b111, the valid flag is 1 and `addr_i[31:12]` equals the stored base.
- R6: While the valid flag is 0, `sel_o` stays low even when the address matches the stored base.
- R7: An access with `fc_i`=3'b111 never raises `sel_o`, even when it falls inside the window.
- R8: `offset_o` equals `addr_i[11:0]` while `sel_o` is high and is zero otherwise.
- R9: After the base is rewritten, addresses in the old window no longer select and addresses in the new window do.
- R10: Offsets 12'h000 and 12'hFFF inside the window select. The address just below the window and the address just above it do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strb_i | input | 1 | Access strobe |
| addr_i | input | 32 | Access address |
| fc_i | input | 3 | Function code; 3'b111 marks CPU space |
| rw_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 32 | Write data for the base register |
| sel_o | output | 1 | Module select |
| offset_o | output | 12 | Offset into the window |
| rdata_o | output | 32 | Base-register read data |
| ack_o | output | 1 | Base-register access acknowledge |

## Verification
The bench writes a base with junk in bits 11:1. A design that stored those bits would read them back, and it would also compare too many address bits, so the window would no longer match. The bench probes both edges of the window and the addresses just outside it, which catches an off-by-one tag slice or an inclusive upper bound. It sends near-miss register accesses, with the wrong function code or the wrong address, and a CPU-space access inside the window. These catch a decoder that ignores the function code: it would acknowledge the near misses or select on the CPU-space access. It also clears the valid flag and relocates the window, which shows whether select still depends on the flag and whether the old window is released.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned WIN_W   = 12;
  localparam int unsigned FC_W    = 3;
  localparam int unsigned TAG_W   = ADDR_W - WIN_W;
  localparam logic [FC_W-1:0]   FC_CPU   = 3'b111;
  localparam logic [ADDR_W-1:0] REG_ADDR = 32'h0003_FF00;

  typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/mwd_base_reg.sv
module mwd_base_reg
  import mwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output tag_t              base_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] rdata_o,
  output logic              ack_o
);
  tag_t base_q;
  logic valid_q;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i[WIN_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      valid_q <= 1'b0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= acc_i;
      rdata_o <= '0;
      if (acc_i) begin
        if (rw_i) begin
          rdata_o <= {base_q, {(WIN_W-1){1'b0}}, valid_q};
        end else begin
          base_q  <= wdata_i[ADDR_W-1:WIN_W];
          valid_q <= wdata_i[0];
        end
      end
    end
  end

  assign base_o  = base_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/mwd_window_cmp.sv
module mwd_window_cmp
  import mwd_pkg::*;
(
  input  logic              strb_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  tag_t              base_i,
  input  logic              valid_i,
  output logic              reg_hit_o,
  output logic              sel_o,
  output logic [WIN_W-1:0]  offset_o
);
  logic cpu_space;

  assign cpu_space = (fc_i == FC_CPU);
  assign reg_hit_o = strb_i && cpu_space && (addr_i == REG_ADDR);
  assign sel_o     = strb_i && !cpu_space && valid_i &&
                     (addr_i[ADDR_W-1:WIN_W] == base_i);
  assign offset_o  = sel_o ? addr_i[WIN_W-1:0] : '0;
endmodule

// File: rtl/module_window_decoder.sv
module module_window_decoder
  import mwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic              sel_o,
  output logic [WIN_W-1:0]  offset_o,
  output logic [ADDR_W-1:0] rdata_o,
  output logic              ack_o
);
  tag_t base;
  logic valid;
  logic reg_hit;

  mwd_window_cmp u_cmp (
    .strb_i   (strb_i),
    .fc_i     (fc_i),
    .addr_i   (addr_i),
    .base_i   (base),
    .valid_i  (valid),
    .reg_hit_o(reg_hit),
    .sel_o    (sel_o),
    .offset_o (offset_o)
  );

  mwd_base_reg u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (reg_hit),
    .rw_i   (rw_i),
    .wdata_i(wdata_i),
    .base_o (base),
    .valid_o(valid),
    .rdata_o(rdata_o),
    .ack_o  (ack_o)
  );
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker
  import mwd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strb_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [FC_W-1:0]   fc_i,
  input logic              rw_i,
  input logic              sel_o,
  input logic [WIN_W-1:0]  offset_o,
  input logic [ADDR_W-1:0] rdata_o,
  input logic              ack_o
);
  logic hit;
  assign hit = strb_i && (fc_i == FC_CPU) && (addr_i == REG_ADDR);

  // R4
  ack_follows_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> ack_o);
  // R4
  ack_only_after_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(hit));
  // R7
  no_cpu_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> (fc_i != FC_CPU) && strb_i);
  // R8
  offset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> (offset_o == '0));
  // R3
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && $past(rw_i)) |-> (rdata_o == '0));
  // R2
  rdata_lowbits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[WIN_W-1:1] == '0);
endmodule

bind module_window_decoder mwd_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strb_i  (strb_i),
  .addr_i  (addr_i),
  .fc_i    (fc_i),
  .rw_i    (rw_i),
  .sel_o   (sel_o),
  .offset_o(offset_o),
  .rdata_o (rdata_o),
  .ack_o   (ack_o)
);

// File: tb/module_window_decoder_test.sv
module module_window_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REG_A = 32'h0003_FF00;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strb_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [2:0]  fc_i = '0;
  logic        rw_i = 1'b1;
  logic [31:0] wdata_i = '0;
  logic        sel_o;
  logic [11:0] offset_o;
  logic [31:0] rdata_o;
  logic        ack_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  module_window_decoder uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns ack and rdata seen the cycle after the strobe
  task automatic reg_acc(input logic rd, input logic [2:0] fc, input logic [31:0] a,
                         input logic [31:0] wd, output logic ack, output logic [31:0] rd_v);
    @(negedge clk_i);
    strb_i = 1'b1; rw_i = rd; fc_i = fc; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    strb_i = 1'b0; rw_i = 1'b1; wdata_i = '0;
    ack = ack_o; rd_v = rdata_o;
    @(negedge clk_i);
    check("R4 ack one cycle only", {31'b0, ack_o}, 32'h0);
  endtask

  task automatic probe(input logic [2:0] fc, input logic [31:0] a,
                       output logic s, output logic [11:0] off);
    @(negedge clk_i);
    strb_i = 1'b1; fc_i = fc; addr_i = a; rw_i = 1'b1;
    #1;
    s = sel_o; off = offset_o;
    @(negedge clk_i);
    strb_i = 1'b0;
  endtask

  task automatic t_reset();
    logic a; logic [31:0] d; logic s; logic [11:0] o;
    check("R1 ack", {31'b0, ack_o}, 32'h0);
    probe(3'b101, 32'h0000_0010, s, o);
    check("R1 sel", {31'b0, s}, 32'h0);
    reg_acc(1'b1, 3'b111, REG_A, '0, a, d);
    check("R1 read", d, 32'h0);
  endtask

  task automatic t_write_read();
    logic a; logic [31:0] d;
    reg_acc(1'b0, 3'b111, REG_A, 32'h1234_5FFF, a, d);
    check("R4 write ack", {31'b0, a}, 32'h1);
    check("R3 write rdata zero", d, 32'h0);
    reg_acc(1'b1, 3'b111, REG_A, '0, a, d);
    check("R3 read ack", {31'b0, a}, 32'h1);
    check("R2 read value", d, 32'h1234_5001);
  endtask

  task automatic t_near_miss();
    logic a; logic [31:0] d;
    reg_acc(1'b0, 3'b101, REG_A, 32'hAAAA_A001, a, d);
    check("R4 wrong fc no ack", {31'b0, a}, 32'h0);
    reg_acc(1'b0, 3'b111, REG_A + 32'h4, 32'hBBBB_B001, a, d);
    check("R4 wrong addr no ack", {31'b0, a}, 32'h0);
    reg_acc(1'b1, 3'b111, REG_A, '0, a, d);
    check("R4 base unchanged", d, 32'h1234_5001);
  endtask

  task automatic t_select();
    logic s; logic [11:0] o;
    probe(3'b101, 32'h1234_5ABC, s, o);
    check("R5 sel", {31'b0, s}, 32'h1);
    check("R8 offset", {20'b0, o}, 32'hABC);
    probe(3'b001, 32'h1234_5000, s, o);
    check("R10 low edge", {31'b0, s}, 32'h1);
    check("R8 offset low", {20'b0, o}, 32'h0);
    probe(3'b010, 32'h1234_5FFF, s, o);
    check("R10 high edge", {31'b0, s}, 32'h1);
    check("R8 offset high", {20'b0, o}, 32'hFFF);
    probe(3'b101, 32'h1234_4FFF, s, o);
    check("R10 below", {31'b0, s}, 32'h0);
    check("R8 offset zero", {20'b0, o}, 32'h0);
    probe(3'b101, 32'h1234_6000, s, o);
    check("R10 above", {31'b0, s}, 32'h0);
    probe(3'b111, 32'h1234_5010, s, o);
    check("R7 cpu space", {31'b0, s}, 32'h0);
  endtask

  task automatic t_relocate();
    logic a; logic [31:0] d; logic s; logic [11:0] o;
    reg_acc(1'b0, 3'b111, REG_A, 32'hFFFF_F001, a, d);
    probe(3'b101, 32'h1234_5100, s, o);
    check("R9 old window", {31'b0, s}, 32'h0);
    probe(3'b101, 32'hFFFF_F100, s, o);
    check("R9 new window", {31'b0, s}, 32'h1);
    check("R9 offset", {20'b0, o}, 32'h100);
  endtask

  task automatic t_invalid();
    logic a; logic [31:0] d; logic s; logic [11:0] o;
    reg_acc(1'b0, 3'b111, REG_A, 32'h0040_0000, a, d);
    probe(3'b101, 32'h0040_0020, s, o);
    check("R6 invalid no sel", {31'b0, s}, 32'h0);
    reg_acc(1'b1, 3'b111, REG_A, '0, a, d);
    check("R2 valid clear read", d, 32'h0040_0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_write_read();
        t_near_miss();
        t_select();
        t_relocate();
        t_invalid();
      end
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule